// File: doc/BRIEF.md
# XModem Checksum-Mode Block Receiver

This block receives a file sent over a serial line with the XModem protocol in its checksum variant. It takes received bytes from a UART receiver as a valid/data pulse stream. It answers the sender with single-byte replies on a valid/ready transmit port. Accepted payload bytes go out through a sequential write port, starting at a base address. The receiver opens the session itself by sending NAK. From then on it frames 132-byte blocks, checks the block number and its complement, checks the payload sum, and acknowledges or rejects each block. The session ends on end-of-transmission, on an escape byte from the sender, or on a block-number fault.

Each block's payload is held in an internal buffer until its checksum is known. Only a block that passes is copied to the write port, as a burst of one byte per cycle. A single timer measures silence on the line. Inside a block it acts as the per-byte timeout, and after an error it acts as the flush window that must pass quietly before a NAK goes out. Bytes that arrive while a reply is waiting on the transmit port are dropped.

Top module: `xmodem_csum_rx`

## Requirements
- R1: After reset the block sends NAK (15h). It sends NAK again each time TIMEOUT_CYC cycles pass with no received byte, until the first byte arrives. The only codes ever sent are NAK (15h) and ACK (06h).
- R2: A block is SOH (01h), then the block number, its bitwise complement, 128 payload bytes and one checksum byte. When the block is good, its 128 payload bytes are written in order, one per wr_en cycle, at consecutive addresses. The first block starts at BASE_ADDR and each later block continues after the previous one. ACK is presented only after the last write.
- R3: The expected block number is 1 after reset. It rises by one, modulo 256, after each accepted block.
- R4: If the block number differs from the expected value, or the next byte is not its complement, fatal is raised and held until reset. No reply is sent and nothing is written.
- R5: If the checksum byte differs from the 8-bit sum of the 128 payload bytes, nothing is written and a NAK follows after a flush. A resent copy of the same block is then accepted at the same addresses.
- R6: If TIMEOUT_CYC cycles pass with no byte while a block is being collected, the block is handled as in R5.
- R7: A NAK that follows an error is sent only after FLUSH_CYC cycles with no received byte. Bytes that arrive in that window are discarded, and each one restarts the window.
- R8: EOT (04h) between blocks is answered with ACK. After a flush, done is raised and held until reset.
- R9: ESC (1Bh) in place of a block start raises aborted and stops the session. No reply is sent.
- R10: Any byte other than 01h, 04h or 1Bh in place of a block start is handled as in R5: flush, then NAK, with no writes.
- R11: Once tx_valid is high, it and tx_data stay unchanged until a cycle in which tx_ready is high.
- R12: After reset, done, aborted, fatal and wr_en are low. At most one of done, aborted and fatal is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle pulse: rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte waiting |
| tx_ready | input | 1 | Transmitter takes the reply byte this cycle |
| tx_data | output | 8 | Reply byte (NAK or ACK) |
| wr_en | output | 1 | Payload write strobe |
| wr_addr | output | ADDR_W | Payload write address |
| wr_data | output | 8 | Payload write data |
| done | output | 1 | Transfer completed after EOT |
| aborted | output | 1 | Transfer stopped by ESC |
| fatal | output | 1 | Transfer stopped by a block-number fault |

## Verification
The checker assumes that rx_valid is a single-cycle pulse per byte. It also assumes that tx_ready may stall for any time, and that the sender sends nothing while a reply is pending. The bench therefore drives each byte for one cycle with an idle cycle after it. Before it sends a new byte, it waits until the previous reply has been taken. The only exception is the flush test, which sends junk on purpose while the design is discarding input. The bench stalls tx_ready only in the opening NAK phase, to check that the reply is held. Payload patterns are computed in the bench, and the expected checksum is summed independently. The bench checks timing windows for the repeated opening NAK, for the flush and for the timeout against the TIMEOUT_CYC and FLUSH_CYC values it sets.

// File: rtl/xmr_pkg.sv
package xmr_pkg;
  localparam logic [7:0] C_SOH = 8'h01;
  localparam logic [7:0] C_EOT = 8'h04;
  localparam logic [7:0] C_ACK = 8'h06;
  localparam logic [7:0] C_NAK = 8'h15;
  localparam logic [7:0] C_ESC = 8'h1B;

  typedef enum logic [3:0] {
    ST_SEND,       // reply byte waiting on the transmit port
    ST_OPEN,       // opening phase: waiting for first byte, NAK on timeout
    ST_IDLE,       // between blocks
    ST_COLLECT,    // gathering block bytes
    ST_CHECK,      // verify number, complement, sum
    ST_COPY,       // stream buffer to write port
    ST_DRAIN,      // let the last write leave before ACK
    ST_FLUSH,      // wait for a quiet line
    ST_DONE,
    ST_ABORT,
    ST_FATAL
  } st_e;
endpackage

// File: rtl/xmr_timer.sv
module xmr_timer #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int FLUSH_CYC   = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic sel_flush,
  output logic expired
);
  localparam int MAXC = (TIMEOUT_CYC > FLUSH_CYC) ? TIMEOUT_CYC : FLUSH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LIM_TO = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LIM_FL = CW'(FLUSH_CYC);
  localparam logic [CW-1:0] SAT    = CW'(MAXC);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit   = sel_flush ? LIM_FL : LIM_TO;
  assign expired = !restart && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xmr_buf.sv
module xmr_buf #(
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xmodem_csum_rx.sv
module xmodem_csum_rx
  import xmr_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              BLK_BYTES   = 128,
  parameter int              TIMEOUT_CYC = 3_000_000,
  parameter int              FLUSH_CYC   = 400_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              aborted,
  output logic              fatal
);
  localparam int IW = $clog2(BLK_BYTES + 4);
  localparam int BW = $clog2(BLK_BYTES);
  localparam logic [IW-1:0] IDX_PAY0 = IW'(2);
  localparam logic [IW-1:0] IDX_PAYN = IW'(BLK_BYTES + 1);
  localparam logic [IW-1:0] IDX_SUM  = IW'(BLK_BYTES + 2);
  localparam logic [BW-1:0] RD_LAST  = BW'(BLK_BYTES - 1);

  st_e               state, st_prev, ret_st;
  logic              tx_valid_q;
  logic [7:0]        tx_data_q;
  logic [IW-1:0]     idx;
  logic [7:0]        blk_q, cpl_q, sum_q, chk_q, exp_q;
  logic [BW-1:0]     rd_idx;
  logic              rd_vld;
  logic [ADDR_W-1:0] addr_q;
  logic              flush_to_done;
  logic              expired;
  logic              buf_we;
  logic [BW-1:0]     buf_waddr;

  assign buf_we    = (state == ST_COLLECT) && rx_valid && (idx >= IDX_PAY0) && (idx <= IDX_PAYN);
  assign buf_waddr = BW'(idx - IDX_PAY0);

  xmr_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .FLUSH_CYC(FLUSH_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (rx_valid || (state != st_prev)),
    .sel_flush (state == ST_FLUSH),
    .expired   (expired)
  );

  xmr_buf #(.DEPTH(BLK_BYTES)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (rx_data),
    .raddr (rd_idx),
    .rdata (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_SEND;
      st_prev       <= ST_SEND;
      ret_st        <= ST_OPEN;
      tx_valid_q    <= 1'b1;
      tx_data_q     <= C_NAK;
      idx           <= '0;
      blk_q         <= '0;
      cpl_q         <= '0;
      sum_q         <= '0;
      chk_q         <= '0;
      exp_q         <= 8'd1;
      rd_idx        <= '0;
      rd_vld        <= 1'b0;
      addr_q        <= BASE_ADDR;
      flush_to_done <= 1'b0;
    end else begin
      st_prev <= state;
      rd_vld  <= 1'b0;
      if (rd_vld) addr_q <= addr_q + 1'b1;
      if (tx_valid_q && tx_ready) tx_valid_q <= 1'b0;

      case (state)
        ST_SEND: if (tx_valid_q && tx_ready) state <= ret_st;

        ST_OPEN, ST_IDLE: begin
          if (rx_valid) begin
            if (rx_data == C_SOH) begin
              state <= ST_COLLECT;
              idx   <= '0;
              sum_q <= '0;
            end else if (rx_data == C_EOT) begin
              state         <= ST_SEND;
              ret_st        <= ST_FLUSH;
              tx_valid_q    <= 1'b1;
              tx_data_q     <= C_ACK;
              flush_to_done <= 1'b1;
            end else if (rx_data == C_ESC) begin
              state <= ST_ABORT;
            end else begin
              state         <= ST_FLUSH;
              flush_to_done <= 1'b0;
            end
          end else if (state == ST_OPEN && expired) begin
            state      <= ST_SEND;
            ret_st     <= ST_OPEN;
            tx_valid_q <= 1'b1;
            tx_data_q  <= C_NAK;
          end
        end

        ST_COLLECT: begin
          if (rx_valid) begin
            idx <= idx + 1'b1;
            if (idx == '0) blk_q <= rx_data;
            else if (idx == IW'(1)) cpl_q <= rx_data;
            else if (idx == IDX_SUM) begin
              chk_q <= rx_data;
              state <= ST_CHECK;
            end else sum_q <= sum_q + rx_data;
          end else if (expired) begin
            state         <= ST_FLUSH;
            flush_to_done <= 1'b0;
          end
        end

        ST_CHECK: begin
          if (blk_q != exp_q || cpl_q != ~blk_q) begin
            state <= ST_FATAL;
          end else if (sum_q != chk_q) begin
            state         <= ST_FLUSH;
            flush_to_done <= 1'b0;
          end else begin
            state  <= ST_COPY;
            rd_idx <= '0;
          end
        end

        ST_COPY: begin
          rd_vld <= 1'b1;
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == RD_LAST) state <= ST_DRAIN;
        end

        ST_DRAIN: begin
          exp_q      <= exp_q + 1'b1;
          state      <= ST_SEND;
          ret_st     <= ST_IDLE;
          tx_valid_q <= 1'b1;
          tx_data_q  <= C_ACK;
        end

        ST_FLUSH: begin
          if (expired) begin
            if (flush_to_done) state <= ST_DONE;
            else begin
              state      <= ST_SEND;
              ret_st     <= ST_IDLE;
              tx_valid_q <= 1'b1;
              tx_data_q  <= C_NAK;
            end
          end
        end

        default: state <= state;
      endcase
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;
  assign wr_en    = rd_vld;
  assign wr_addr  = addr_q;
  assign done     = (state == ST_DONE);
  assign aborted  = (state == ST_ABORT);
  assign fatal    = (state == ST_FATAL);
endmodule

// File: rtl/xmr_chk.sv
module xmr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              aborted,
  input logic              fatal
);
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_tx_code_r1: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_data == 8'h15 || tx_data == 8'h06));

  p_wr_seq_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && $past(wr_en) |-> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

  p_term_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, aborted, fatal}));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_fatal_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    fatal |-> !tx_valid && !wr_en);

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    aborted |-> !tx_valid && !wr_en);
endmodule

bind xmodem_csum_rx xmr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .done     (done),
  .aborted  (aborted),
  .fatal    (fatal)
);

// File: tb/xmodem_csum_rx_bench.sv
`timescale 1ns/100ps
module xmodem_csum_rx_bench;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = 10'h040;
  localparam int TO = 200;
  localparam int FL = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_ready = 1'b1;
  logic tx_valid, wr_en, done, aborted, fatal;
  logic [7:0] tx_data, wr_data;
  logic [AW-1:0] wr_addr;

  always #2 clk = ~clk;

  xmodem_csum_rx #(.ADDR_W(AW), .BASE_ADDR(BASE), .BLK_BYTES(128),
                   .TIMEOUT_CYC(TO), .FLUSH_CYC(FL)) u_xmodem_csum_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .aborted(aborted), .fatal(fatal));

  int checks = 0, fails = 0;
  int cyc = 0;
  int tx_n = 0, wr_n = 0;
  int last_wr_cyc = 0, last_rx_cyc = 0;
  logic [7:0] tx_log [64];
  int         tx_cyc [64];
  logic [7:0] mem [1024];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready) begin
        if (tx_n < 64) begin
          tx_log[tx_n] = tx_data;
          tx_cyc[tx_n] = cyc;
        end
        tx_n = tx_n + 1;
      end
      if (wr_en) begin
        mem[wr_addr] = wr_data;
        wr_n = wr_n + 1;
        last_wr_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_valid = 1'b0;
    tick(4);
    tx_n = 0;
    wr_n = 0;
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    last_rx_cyc = cyc;
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(i * 7 + seed * 13 + 1);
  endfunction

  task automatic send_block(input logic [7:0] bn, input logic [7:0] bc,
                            input int seed, input bit bad);
    logic [7:0] s;
    s = '0;
    send_byte(8'h01);
    send_byte(bn);
    send_byte(bc);
    for (int i = 0; i < 128; i++) begin
      send_byte(pat(seed, i));
      s = s + pat(seed, i);
    end
    send_byte(bad ? s + 8'd1 : s);
  endtask

  task automatic wait_tx(input int n0, input int lim, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < lim; k++) begin
      tick(1);
      if (tx_n > n0) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic check_block(input int seed, input int off, input string tag);
    int bad = 0;
    for (int i = 0; i < 128; i++)
      if (mem[BASE + AW'(off + i)] !== pat(seed, i)) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  // reset state, held reply, repeated opening NAK
  task automatic t_open();
    bit ok;
    tx_ready = 1'b0;
    do_reset();
    chk(!done && !aborted && !fatal, "R12 flags after reset", {done, aborted, fatal}, 0);
    chk(!wr_en, "R12 wr_en after reset", wr_en, 0);
    tick(20);
    chk(tx_valid && tx_data == 8'h15 && tx_n == 0, "R11 NAK held while not ready", tx_data, 8'h15);
    tx_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_tx(tx_n, TO + 20, ok);
    end
    chk(tx_n >= 3, "R1 NAK count", tx_n, 3);
    chk(tx_log[1] == 8'h15 && tx_log[2] == 8'h15, "R1 repeated code", tx_log[2], 8'h15);
    chk(tx_cyc[2] - tx_cyc[1] >= TO && tx_cyc[2] - tx_cyc[1] <= TO + 3,
        "R1 NAK spacing", tx_cyc[2] - tx_cyc[1], TO);
  endtask

  task automatic t_good1();
    bit ok;
    int n0 = tx_n, w0 = wr_n;
    send_block(8'h01, 8'hFE, 1, 1'b0);
    wait_tx(n0, 400, ok);
    chk(ok && tx_log[n0] == 8'h06, "R2 ACK for block 1", tx_log[n0], 8'h06);
    chk(wr_n - w0 == 128, "R2 write count block 1", wr_n - w0, 128);
    check_block(1, 0, "R2 data of block 1 at base");
    chk(tx_cyc[n0] > last_wr_cyc, "R2 ACK after last write", tx_cyc[n0], last_wr_cyc);
  endtask

  task automatic t_badsum();
    bit ok;
    int n0 = tx_n, w0 = wr_n;
    send_block(8'h02, 8'hFD, 2, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick(FL / 2);
      send_byte(8'h55);
    end
    chk(tx_n == n0, "R7 no NAK during noisy flush", tx_n, n0);
    wait_tx(n0, 400, ok);
    chk(ok && tx_log[n0] == 8'h15, "R5 NAK on bad sum", tx_log[n0], 8'h15);
    chk(wr_n == w0, "R5 no writes on bad sum", wr_n - w0, 0);
    chk(tx_cyc[n0] - last_rx_cyc >= FL && tx_cyc[n0] - last_rx_cyc <= FL + 4,
        "R7 quiet window before NAK", tx_cyc[n0] - last_rx_cyc, FL);
  endtask

  task automatic t_resend2();
    bit ok;
    int n0 = tx_n, w0 = wr_n;
    send_block(8'h02, 8'hFD, 2, 1'b0);
    wait_tx(n0, 400, ok);
    chk(ok && tx_log[n0] == 8'h06, "R3 block 2 accepted", tx_log[n0], 8'h06);
    chk(wr_n - w0 == 128, "R5 resent block written", wr_n - w0, 128);
    check_block(2, 128, "R2 block 2 follows block 1");
  endtask

  task automatic t_timeout();
    bit ok;
    int n0 = tx_n, w0 = wr_n;
    send_byte(8'h01);
    send_byte(8'h03);
    send_byte(8'hFC);
    for (int i = 0; i < 10; i++) send_byte(8'hA0);
    wait_tx(n0, TO + FL + 100, ok);
    chk(ok && tx_log[n0] == 8'h15, "R6 NAK after byte timeout", tx_log[n0], 8'h15);
    chk(tx_cyc[n0] - last_rx_cyc >= TO + FL, "R6 timeout plus flush delay",
        tx_cyc[n0] - last_rx_cyc, TO + FL);
    chk(wr_n == w0, "R6 no writes on timeout", wr_n - w0, 0);
  endtask

  task automatic t_stray();
    bit ok;
    int n0 = tx_n, w0 = wr_n;
    send_byte(8'h55);
    wait_tx(n0, FL + 50, ok);
    chk(ok && tx_log[n0] == 8'h15, "R10 NAK on stray byte", tx_log[n0], 8'h15);
    chk(wr_n == w0, "R10 no writes on stray byte", wr_n - w0, 0);
  endtask

  task automatic t_good3();
    bit ok;
    int n0 = tx_n;
    send_block(8'h03, 8'hFC, 3, 1'b0);
    wait_tx(n0, 400, ok);
    chk(ok && tx_log[n0] == 8'h06, "R3 block 3 accepted after errors", tx_log[n0], 8'h06);
    check_block(3, 256, "R2 block 3 follows block 2");
  endtask

  task automatic t_eot();
    bit ok;
    int n0 = tx_n;
    send_byte(8'h04);
    wait_tx(n0, 50, ok);
    chk(ok && tx_log[n0] == 8'h06, "R8 ACK on EOT", tx_log[n0], 8'h06);
    chk(!done, "R8 done waits for flush", done, 0);
    tick(FL + 10);
    chk(done && !aborted && !fatal, "R8 done after flush", done, 1);
    chk(tx_n == n0 + 1, "R8 single reply", tx_n, n0 + 1);
  endtask

  task automatic t_esc();
    bit ok;
    int n0;
    do_reset();
    wait_tx(0, 50, ok);
    n0 = tx_n;
    send_byte(8'h1B);
    tick(3);
    chk(aborted && !done && !fatal, "R9 aborted on ESC", aborted, 1);
    tick(2 * TO);
    chk(tx_n == n0, "R9 no reply after ESC", tx_n, n0);
  endtask

  task automatic t_fatal(input logic [7:0] bn, input logic [7:0] bc, input string tag);
    bit ok;
    int n0;
    do_reset();
    wait_tx(0, 50, ok);
    n0 = tx_n;
    send_block(bn, bc, 5, 1'b0);
    tick(10);
    chk(fatal && !done && !aborted, {"R4 fatal on ", tag}, fatal, 1);
    tick(2 * TO);
    chk(tx_n == n0 && wr_n == 0, {"R4 silent after ", tag}, tx_n - n0 + wr_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_open();
    t_good1();
    t_badsum();
    t_resend2();
    t_timeout();
    t_stray();
    t_good3();
    t_eot();
    t_esc();
    t_fatal(8'h02, 8'hFD, "wrong number");
    t_fatal(8'h01, 8'hFF, "bad complement");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule